// File: doc/BRIEF.md
# Transmit Descriptor Ring Manager

This block owns a small circular ring of transmit descriptors that a host and a transmit DMA engine share. Each slot holds a 16-bit status word, a 16-bit byte count and a 32-bit buffer pointer. The host submits one frame at a time by giving a length and a buffer pointer. The block answers with a single accept or reject response. On accept, the block fills the slot at the producer index, hands that slot to the engine by setting its ready flag, and pulses a continue strobe toward the engine.

Reclaim is lazy. Slots the engine has finished with are not recycled when the engine finishes. They are recycled when the next submit arrives. Starting at the reclaim index, the block walks forward one slot per cycle while fewer than all slots are free, and it stops at the first slot whose ready flag is still set. Only after this walk does it judge the request. The engine side, modelled here as a completion port, clears the ready flag of a named slot. A read port exposes any slot's contents to the engine or to an observer.

Top module: `tx_desc_ring`

## Requirements
- R1: After reset, every slot has length 0 and pointer 0. Every status word is 0, except the last slot, which holds only the wrap flag (bit 13, value 0x2000). The free count equals the ring size and subReady is 1.
- R2: An accepted request writes its length and pointer into the producer slot. It ORs the ready flag (bit 15), last flag (bit 11) and CRC-append flag (bit 10) into that slot's status and keeps any wrap flag already there. The result is 0x8C00 for an ordinary slot and 0xAC00 for the last slot.
- R3: After an accept, the producer index advances by one and returns to 0 after the last slot. The free count drops by one, and dmaKick is high for exactly the cycle in which the accepting response is shown.
- R4: A request with length 0 or length above 1500 is rejected. It writes no slot and raises no dmaKick. A length of exactly 1500 is accepted.
- R5: A request is rejected when the free count is 0 after the reclaim walk.
- R6: Before the accept or reject decision, slots are reclaimed starting at the reclaim index, one per cycle, while the free count is below the ring size. The walk stops at the first slot whose ready flag is set. This walk runs even for requests that are then rejected.
- R7: A reclaimed slot's status becomes 0. For the last slot it becomes exactly 0x2000. Each reclaim raises the free count by one and advances the reclaim index modulo the ring size.
- R8: A completion on hwDoneValid clears only bit 15 of the status of slot hwDoneIdx. The other status bits stay as they were.
- R9: subValid is ignored while subReady is low. Each request that is taken yields exactly one response.
- R10: respValid is a single-cycle pulse. dmaKick is never high without an accepting response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; initializes the ring |
| subValid | input | 1 | Submit request, taken when subReady is high |
| subLen | input | 16 | Frame length in bytes |
| subAddr | input | 32 | Frame buffer pointer |
| subReady | output | 1 | Block idle and able to take a request |
| respValid | output | 1 | One-cycle response pulse |
| respAccept | output | 1 | With respValid: 1 accepted, 0 rejected |
| dmaKick | output | 1 | Continue strobe to the DMA engine |
| hwDoneValid | input | 1 | Engine completion strobe |
| hwDoneIdx | input | $clog2(RING) | Slot whose ready flag is cleared |
| rdIdx | input | $clog2(RING) | Slot selected for read-out |
| rdStat | output | 16 | Status word of slot rdIdx |
| rdLen | output | 16 | Length of slot rdIdx |
| rdAddr | output | 32 | Buffer pointer of slot rdIdx |
| freeCount | output | $clog2(RING+1) | Number of free slots |

## Verification
A drifting reclaim index, or a free count out of step with it, shows at the ports in two ways. A wrongly rejected or accepted submit appears within a few cycles of the next request. A slot status other than 0, 0x2000 or the flagged value also appears on the read port. A lost wrap flag shows as 0x8C00 instead of 0xAC00 on the last slot as soon as that slot is filled, and as a non-0x2000 value after it is reclaimed. A walk that does not stop at a ready slot becomes visible once a later slot has completed out of order: that slot's status is cleared too early, and the free count rises above what the bench expects on the very next response.

// File: rtl/txring_pkg.sv
package txring_pkg;
  localparam int STAT_W  = 16;
  localparam int LEN_W   = 16;
  localparam int ADDR_W  = 32;
  localparam int MAX_LEN = 1500;

  localparam int BIT_READY = 15;
  localparam int BIT_WRAP  = 13;
  localparam int BIT_LAST  = 11;
  localparam int BIT_CRC   = 10;

  localparam logic [STAT_W-1:0] WRAP_MASK = STAT_W'(1) << BIT_WRAP;
  localparam logic [STAT_W-1:0] POST_MASK = (STAT_W'(1) << BIT_READY) |
                                            (STAT_W'(1) << BIT_LAST)  |
                                            (STAT_W'(1) << BIT_CRC);

  typedef struct packed {
    logic latchReq;
    logic reclaimOne;
    logic commit;
  } ringCmd_t;
endpackage

// File: rtl/txring_store.sv
module txring_store
  import txring_pkg::*;
#(
  parameter int RING = 4,
  localparam int IW = (RING > 1) ? $clog2(RING) : 1,
  localparam int FW = $clog2(RING + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ringCmd_t          cmd,
  input  logic [LEN_W-1:0]  subLen,
  input  logic [ADDR_W-1:0] subAddr,
  input  logic              hwDoneValid,
  input  logic [IW-1:0]     hwDoneIdx,
  input  logic [IW-1:0]     rdIdx,
  output logic [STAT_W-1:0] rdStat,
  output logic [LEN_W-1:0]  rdLen,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              headReady,
  output logic              lenOk,
  output logic [FW-1:0]     freeCount
);
  localparam logic [IW-1:0] LAST_IDX = IW'(RING - 1);

  logic [STAT_W-1:0] statMem [RING];
  logic [STAT_W-1:0] statNxt [RING];
  logic [LEN_W-1:0]  lenMem  [RING];
  logic [ADDR_W-1:0] addrMem [RING];

  logic [IW-1:0]     prodIdx, reclaimIdx;
  logic [LEN_W-1:0]  reqLen;
  logic [ADDR_W-1:0] reqAddr;

  function automatic logic [IW-1:0] stepIdx(input logic [IW-1:0] i);
    return (i == LAST_IDX) ? '0 : i + IW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reqLen  <= '0;
      reqAddr <= '0;
    end else if (cmd.latchReq) begin
      reqLen  <= subLen;
      reqAddr <= subAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prodIdx    <= '0;
      reclaimIdx <= '0;
      freeCount  <= FW'(RING);
    end else begin
      if (cmd.reclaimOne) begin
        reclaimIdx <= stepIdx(reclaimIdx);
        freeCount  <= freeCount + FW'(1);
      end else if (cmd.commit) begin
        prodIdx    <= stepIdx(prodIdx);
        freeCount  <= freeCount - FW'(1);
      end
    end
  end

  for (genvar g = 0; g < RING; g++) begin : g_slot
    localparam logic [STAT_W-1:0] CLEAN = (g == RING - 1) ? WRAP_MASK : '0;
    logic reclaimHit, commitHit, hwHit;

    assign reclaimHit = cmd.reclaimOne && (reclaimIdx == IW'(g));
    assign commitHit  = cmd.commit && (prodIdx == IW'(g));
    assign hwHit      = hwDoneValid && (hwDoneIdx == IW'(g));

    always_comb begin
      statNxt[g] = statMem[g];
      if (reclaimHit) statNxt[g] = CLEAN;
      if (commitHit)  statNxt[g] = statMem[g] | POST_MASK;
      if (hwHit)      statNxt[g][BIT_READY] = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        statMem[g] <= CLEAN;
        lenMem[g]  <= '0;
        addrMem[g] <= '0;
      end else begin
        statMem[g] <= statNxt[g];
        if (commitHit) begin
          lenMem[g]  <= reqLen;
          addrMem[g] <= reqAddr;
        end
      end
    end
  end

  assign headReady = statMem[reclaimIdx][BIT_READY];
  assign lenOk     = (reqLen != '0) && (reqLen <= LEN_W'(MAX_LEN));

  always_comb begin
    rdStat = '0;
    rdLen  = '0;
    rdAddr = '0;
    if (int'(rdIdx) < RING) begin
      rdStat = statMem[rdIdx];
      rdLen  = lenMem[rdIdx];
      rdAddr = addrMem[rdIdx];
    end
  end
endmodule

// File: rtl/txring_ctrl.sv
module txring_ctrl
  import txring_pkg::*;
#(
  parameter int RING = 4,
  localparam int FW = $clog2(RING + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          subValid,
  input  logic          headReady,
  input  logic          lenOk,
  input  logic [FW-1:0] freeCount,
  output ringCmd_t      cmd,
  output logic          subReady,
  output logic          respValid,
  output logic          respAccept,
  output logic          dmaKick
);
  typedef enum logic [1:0] {S_IDLE, S_WALK, S_DECIDE} ctrlState_t;
  ctrlState_t state, stateNxt;

  always_comb begin
    cmd      = '0;
    stateNxt = state;
    unique case (state)
      S_IDLE: if (subValid) begin
        cmd.latchReq = 1'b1;
        stateNxt     = S_WALK;
      end
      S_WALK: begin
        if ((freeCount < FW'(RING)) && !headReady) cmd.reclaimOne = 1'b1;
        else stateNxt = S_DECIDE;
      end
      S_DECIDE: begin
        cmd.commit = lenOk && (freeCount != '0);
        stateNxt   = S_IDLE;
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      respValid  <= 1'b0;
      respAccept <= 1'b0;
      dmaKick    <= 1'b0;
    end else begin
      state      <= stateNxt;
      respValid  <= (state == S_DECIDE);
      respAccept <= cmd.commit;
      dmaKick    <= cmd.commit;
    end
  end

  assign subReady = (state == S_IDLE);
endmodule

// File: rtl/tx_desc_ring.sv
module tx_desc_ring
  import txring_pkg::*;
#(
  parameter int RING = 4,
  localparam int IW = (RING > 1) ? $clog2(RING) : 1,
  localparam int FW = $clog2(RING + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              subValid,
  input  logic [LEN_W-1:0]  subLen,
  input  logic [ADDR_W-1:0] subAddr,
  output logic              subReady,
  output logic              respValid,
  output logic              respAccept,
  output logic              dmaKick,
  input  logic              hwDoneValid,
  input  logic [IW-1:0]     hwDoneIdx,
  input  logic [IW-1:0]     rdIdx,
  output logic [STAT_W-1:0] rdStat,
  output logic [LEN_W-1:0]  rdLen,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [FW-1:0]     freeCount
);
  ringCmd_t cmd;
  logic     headReady, lenOk;

  txring_ctrl #(.RING(RING)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .subValid(subValid), .headReady(headReady),
    .lenOk(lenOk), .freeCount(freeCount), .cmd(cmd), .subReady(subReady),
    .respValid(respValid), .respAccept(respAccept), .dmaKick(dmaKick)
  );

  txring_store #(.RING(RING)) u_store (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .subLen(subLen), .subAddr(subAddr),
    .hwDoneValid(hwDoneValid), .hwDoneIdx(hwDoneIdx), .rdIdx(rdIdx),
    .rdStat(rdStat), .rdLen(rdLen), .rdAddr(rdAddr), .headReady(headReady),
    .lenOk(lenOk), .freeCount(freeCount)
  );
endmodule

// File: rtl/tx_desc_ring_chk.sv
module tx_desc_ring_chk #(
  parameter int RING = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       subValid,
  input logic                       subReady,
  input logic                       respValid,
  input logic                       respAccept,
  input logic                       dmaKick,
  input logic [$clog2(RING+1)-1:0]  freeCount
);
  // R7: the free count never exceeds the ring size
  a_r7_free_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    int'(freeCount) <= RING);

  // R10: dmaKick only with an accepting response
  a_r10_kick_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
    dmaKick |-> (respValid && respAccept));

  // R10: the response is a single-cycle pulse
  a_r10_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    respValid |=> !respValid);

  // R3: an accept consumes exactly one free slot
  a_r3_free_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (respValid && respAccept) |-> (freeCount == $past(freeCount) - 1'b1));

  // R5: no accept while the ring was full at decision time
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (respValid && respAccept) |-> ($past(freeCount) != '0));

  // R9: a response only follows a busy cycle
  a_r9_busy_before_resp: assert property (@(posedge clk) disable iff (!rst_n)
    respValid |-> $past(!subReady));
endmodule

bind tx_desc_ring tx_desc_ring_chk #(.RING(RING)) u_chk (
  .clk(clk), .rst_n(rst_n), .subValid(subValid), .subReady(subReady),
  .respValid(respValid), .respAccept(respAccept), .dmaKick(dmaKick),
  .freeCount(freeCount)
);

// File: tb/tb_tx_desc_ring.sv
module tb_tx_desc_ring;
  localparam int RING = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        subValid = 1'b0;
  logic [15:0] subLen = '0;
  logic [31:0] subAddr = '0;
  logic        subReady, respValid, respAccept, dmaKick;
  logic        hwDoneValid = 1'b0;
  logic [1:0]  hwDoneIdx = '0;
  logic [1:0]  rdIdx = '0;
  logic [15:0] rdStat, rdLen;
  logic [31:0] rdAddr;
  logic [2:0]  freeCount;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  tx_desc_ring #(.RING(RING)) dut (
    .clk(clk), .rst_n(rst_n), .subValid(subValid), .subLen(subLen),
    .subAddr(subAddr), .subReady(subReady), .respValid(respValid),
    .respAccept(respAccept), .dmaKick(dmaKick), .hwDoneValid(hwDoneValid),
    .hwDoneIdx(hwDoneIdx), .rdIdx(rdIdx), .rdStat(rdStat), .rdLen(rdLen),
    .rdAddr(rdAddr), .freeCount(freeCount)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic chkSlot(input string req, input int idx, input logic [15:0] st,
                         input logic [15:0] ln, input logic [31:0] ad);
    rdIdx = 2'(idx);
    #1;
    chk(req, $sformatf("slot%0d status", idx), 32'(rdStat), 32'(st));
    chk(req, $sformatf("slot%0d length", idx), 32'(rdLen), 32'(ln));
    chk(req, $sformatf("slot%0d pointer", idx), rdAddr, ad);
  endtask

  task automatic chkStat(input string req, input int idx, input logic [15:0] st);
    rdIdx = 2'(idx);
    #1;
    chk(req, $sformatf("slot%0d status", idx), 32'(rdStat), 32'(st));
  endtask

  task automatic submit(input logic [15:0] len, input logic [31:0] addr,
                        input int hold, output logic acc, output int resps,
                        output int kicks);
    @(negedge clk);
    subValid = 1'b1;
    subLen   = len;
    subAddr  = addr;
    acc = 1'b0; resps = 0; kicks = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (respValid) begin resps++; acc = respAccept; end
      if (dmaKick) kicks++;
      if (c + 1 >= hold) subValid = 1'b0;
    end
  endtask

  task automatic complete(input int idx);
    @(negedge clk);
    hwDoneValid = 1'b1;
    hwDoneIdx   = 2'(idx);
    @(negedge clk);
    hwDoneValid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "freeCount", 32'(freeCount), 32'd4);
    chk("R1", "subReady", 32'(subReady), 32'd1);
    chk("R1", "respValid", 32'(respValid), 32'd0);
    for (int i = 0; i < RING; i++)
      chkSlot("R1", i, (i == RING - 1) ? 16'h2000 : 16'h0000, 16'd0, 32'd0);
  endtask

  task automatic t_first_accept;
    logic a; int r, k;
    submit(16'd100, 32'h1000_0000, 1, a, r, k);
    chk("R2", "accept", 32'(a), 32'd1);
    chk("R10", "response count", 32'(r), 32'd1);
    chk("R3", "kick count", 32'(k), 32'd1);
    chk("R3", "freeCount", 32'(freeCount), 32'd3);
    chkSlot("R2", 0, 16'h8C00, 16'd100, 32'h1000_0000);
  endtask

  task automatic t_length_limits;
    logic a; int r, k;
    submit(16'd0, 32'hDEAD_0000, 1, a, r, k);
    chk("R4", "zero length accept", 32'(a), 32'd0);
    chk("R4", "zero length kick", 32'(k), 32'd0);
    chk("R4", "freeCount", 32'(freeCount), 32'd3);
    chkSlot("R4", 1, 16'h0000, 16'd0, 32'd0);
    submit(16'd1501, 32'hDEAD_0001, 1, a, r, k);
    chk("R4", "oversize accept", 32'(a), 32'd0);
    chk("R10", "reject response count", 32'(r), 32'd1);
    chkSlot("R4", 1, 16'h0000, 16'd0, 32'd0);
    submit(16'd1500, 32'h2000_0000, 1, a, r, k);
    chk("R4", "1500 accept", 32'(a), 32'd1);
    chkSlot("R3", 1, 16'h8C00, 16'd1500, 32'h2000_0000);
    chk("R3", "freeCount", 32'(freeCount), 32'd2);
  endtask

  task automatic t_fill_and_full;
    logic a; int r, k;
    submit(16'd64, 32'h3000_0000, 1, a, r, k);
    chk("R2", "slot2 accept", 32'(a), 32'd1);
    submit(16'd1400, 32'h4000_0000, 1, a, r, k);
    chk("R2", "slot3 accept", 32'(a), 32'd1);
    chkSlot("R2", 3, 16'hAC00, 16'd1400, 32'h4000_0000);
    chk("R3", "freeCount full", 32'(freeCount), 32'd0);
    submit(16'd200, 32'h5000_0000, 1, a, r, k);
    chk("R5", "full accept", 32'(a), 32'd0);
    chk("R5", "full kick", 32'(k), 32'd0);
    chk("R5", "freeCount", 32'(freeCount), 32'd0);
  endtask

  task automatic t_out_of_order;
    logic a; int r, k;
    complete(1);
    chkStat("R8", 1, 16'h0C00);
    chkStat("R8", 0, 16'h8C00);
    submit(16'd300, 32'h6000_0000, 1, a, r, k);
    chk("R6", "head still owned accept", 32'(a), 32'd0);
    chk("R6", "freeCount", 32'(freeCount), 32'd0);
    chkStat("R6", 1, 16'h0C00);
  endtask

  task automatic t_bulk_reclaim;
    logic a; int r, k;
    complete(0);
    complete(2);
    complete(3);
    submit(16'd700, 32'h7000_0000, 2, a, r, k);
    chk("R6", "accept after walk", 32'(a), 32'd1);
    chk("R9", "responses for held request", 32'(r), 32'd1);
    chk("R9", "kicks for held request", 32'(k), 32'd1);
    chk("R7", "freeCount", 32'(freeCount), 32'd3);
    chkStat("R7", 1, 16'h0000);
    chkStat("R7", 2, 16'h0000);
    chkStat("R7", 3, 16'h2000);
    chkSlot("R3", 0, 16'h8C00, 16'd700, 32'h7000_0000);
  endtask

  task automatic t_reject_still_reclaims;
    logic a; int r, k;
    complete(0);
    submit(16'd0, 32'h0, 1, a, r, k);
    chk("R6", "zero length accept", 32'(a), 32'd0);
    chk("R6", "freeCount after walk", 32'(freeCount), 32'd4);
    chkStat("R7", 0, 16'h0000);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_accept();
    t_length_limits();
    t_fill_and_full();
    t_out_of_order();
    t_bulk_reclaim();
    t_reject_still_reclaims();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule